// File: doc/BRIEF.md
# Encoded Interval Watchdog Timer

This block is a watchdog whose timeout comes from a single control byte. The two low bits of the byte select a resolution and the next five bits hold a multiplier. The count runs in ticks of one sixteenth of a second, supplied from outside as a single-cycle enable. The top bit steers what happens at expiry. When it is set, the block requests a system reset, clears its own control byte and strobes a clear for one bit of an external calendar register. When it is clear, the block raises a one-cycle interrupt pulse.

Software services the watchdog by touching the control byte. Writing the byte loads a new interval. Reading it back restarts the count from the stored interval, so a plain read is enough to keep the timer from firing. Every restart drops the timeout flag, and every expiry raises it. After expiry the counter stays idle until the next access. A multiplier of zero switches the watchdog off.

Top module: `wdt_encoded_timer`

## Requirements
- R1: The control byte holds the resolution code in bits 1:0, the multiplier in bits 6:2 and the steering bit in bit 7. The timeout is multiplier × 4^resolution ticks (1 to 1984).
- R2: A write stores the byte, which appears on `wd_rdata` in the next cycle, clears `wd_timeout` and restarts the count with the new interval.
- R3: A read leaves the stored byte unchanged, clears `wd_timeout` and restarts the count from the stored interval.
- R4: With a multiplier of zero, including a byte of zero, the watchdog never expires, whatever number of ticks arrives.
- R5: Expiry happens on the Nth tick after a restart, where N is the interval. `wd_timeout` rises in the cycle after that tick, and no earlier tick sets it.
- R6: At expiry with bit 7 set, `wd_rst_req` and `wd_cent_clr` are each high for exactly one cycle, and the stored byte reads 0x00 from that cycle on.
- R7: At expiry with bit 7 clear, `wd_irq` is high for exactly one cycle and the stored byte is kept.
- R8: After expiry the counter is idle. Further ticks produce no pulse, and `wd_timeout` stays high until the next read or write.
- R9: While `rst_n` is low, the stored byte, the counter, the flag and all pulse outputs are 0.
- R10: A write and a read in the same cycle act as a write. A tick in the same cycle as a restart is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wd_wr | input | 1 | Write strobe for the control byte |
| wd_rd | input | 1 | Read strobe for the control byte; restarts the count |
| wd_wdata | input | 8 | Write data |
| tick_16 | input | 1 | One-cycle enable, once every 1/16 second |
| wd_rdata | output | 8 | Stored control byte |
| wd_timeout | output | 1 | Timeout flag |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle interrupt pulse |
| wd_cent_clr | output | 1 | One-cycle clear strobe for one bit of an external register |

## Verification
The assertions check, on every cycle, several properties. Each pulse lasts one cycle. A reset request never coincides with an interrupt. The byte reads zero whenever a reset request is issued. Every access clears the flag. A rising flag always comes with exactly one pulse. The counter is idle once it has fired. Only the bench scenarios can show that expiry lands on exactly the Nth tick for different multiplier and resolution codes, which covers the 1-tick and 1984-tick extremes. The scenarios also show that a read in mid-count pushes expiry out by a full interval, that a write beats a simultaneous read, and that a zero multiplier keeps the timer silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_MULT_W = 5;
  localparam int WDT_RES_W  = 2;

  // width of a counter able to hold max multiplier shifted by max resolution
  function automatic int wdt_cnt_width(input int mult_w, input int res_w);
    return mult_w + 2 * ((1 << res_w) - 1);
  endfunction
endpackage

// File: rtl/wdt_interval_dec.sv
module wdt_interval_dec #(
  parameter int MULT_W = wdt_pkg::WDT_MULT_W,
  parameter int RES_W  = wdt_pkg::WDT_RES_W,
  localparam int CODE_W = MULT_W + RES_W,
  localparam int CNT_W  = wdt_pkg::wdt_cnt_width(MULT_W, RES_W),
  localparam int NCODES = 1 << RES_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  ticks
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  cand [NCODES];

  assign res  = code[RES_W-1:0];
  assign mult = code[CODE_W-1:RES_W];

  // one shifted candidate per resolution code, 4x apart
  for (genvar r = 0; r < NCODES; r++) begin : g_res
    assign cand[r] = {{(CNT_W-MULT_W){1'b0}}, mult} << (2 * r);
  end

  assign ticks = cand[res];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             cnt_en;
  logic             last;

  assign last   = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign expire = act_q & tick & last & ~load;
  assign cnt_en = load | (act_q & tick);
  assign busy   = act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = load_val;
      act_d = (load_val != '0);
    end else if (act_q && tick) begin
      if (last) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0)) else $error("counter active at zero"); // R5
  AST_ZERO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !act_q) else $error("zero interval started"); // R4
endmodule

// File: rtl/wdt_expiry_ctl.sv
module wdt_expiry_ctl #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              expire,
  output logic [BYTE_W-1:0] ctrl,
  output logic              flag,
  output logic              rst_req,
  output logic              irq,
  output logic              cent_clr
);
  localparam int STEER = BYTE_W - 1;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              flag_q, flag_d;
  logic              rreq_q, rreq_d;
  logic              irq_q, irq_d;
  logic              clr_q, clr_d;

  assign ctrl_en = wr | (expire & ctrl_q[STEER]);

  always_comb begin
    ctrl_d = wr ? wdata : '0;
    flag_d = flag_q;
    if (wr || rd)   flag_d = 1'b0;
    else if (expire) flag_d = 1'b1;
    rreq_d = expire &  ctrl_q[STEER];
    clr_d  = expire &  ctrl_q[STEER];
    irq_d  = expire & ~ctrl_q[STEER];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rreq_q <= 1'b0;
      irq_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rreq_q <= rreq_d;
      irq_q  <= irq_d;
      clr_q  <= clr_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign flag     = flag_q;
  assign rst_req  = rreq_q;
  assign irq      = irq_q;
  assign cent_clr = clr_q;

  AST_RREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> !rreq_q) else $error("reset request too long"); // R6
  AST_RREQ_CLEARS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |-> (ctrl_q == '0)) else $error("byte kept after reset request"); // R6
  AST_CLR_NEEDS_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(ctrl_q[STEER])) else $error("clear strobe without steer"); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q) else $error("interrupt too long"); // R7
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rreq_q)) else $error("both expiry actions"); // R7
  AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) |=> !flag_q) else $error("flag survives access"); // R3
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (irq_q ^ rreq_q)) else $error("flag rose without action"); // R5
endmodule

// File: rtl/wdt_encoded_timer.sv
module wdt_encoded_timer #(
  parameter int MULT_W = wdt_pkg::WDT_MULT_W,
  parameter int RES_W  = wdt_pkg::WDT_RES_W,
  localparam int CODE_W = MULT_W + RES_W,
  localparam int BYTE_W = CODE_W + 1,
  localparam int CNT_W  = wdt_pkg::wdt_cnt_width(MULT_W, RES_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_wr,
  input  logic              wd_rd,
  input  logic [BYTE_W-1:0] wd_wdata,
  input  logic              tick_16,
  output logic [BYTE_W-1:0] wd_rdata,
  output logic              wd_timeout,
  output logic              wd_rst_req,
  output logic              wd_irq,
  output logic              wd_cent_clr
);
  logic              rst_meta_q, rst_s_q;
  logic              restart;
  logic [CODE_W-1:0] code_src;
  logic [CNT_W-1:0]  interval;
  logic              expire;
  logic              busy;
  logic [BYTE_W-1:0] ctrl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  assign restart  = wd_wr | wd_rd;
  assign code_src = wd_wr ? wd_wdata[CODE_W-1:0] : ctrl[CODE_W-1:0];

  wdt_interval_dec #(.MULT_W(MULT_W), .RES_W(RES_W)) u_dec (
    .code  (code_src),
    .ticks (interval)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .load     (restart),
    .load_val (interval),
    .tick     (tick_16),
    .expire   (expire),
    .busy     (busy)
  );

  wdt_expiry_ctl #(.BYTE_W(BYTE_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .wr       (wd_wr),
    .rd       (wd_rd),
    .wdata    (wd_wdata),
    .expire   (expire),
    .ctrl     (ctrl),
    .flag     (wd_timeout),
    .rst_req  (wd_rst_req),
    .irq      (wd_irq),
    .cent_clr (wd_cent_clr)
  );

  assign wd_rdata = ctrl;

  AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_s_q)
    (wd_rst_req || wd_irq) |-> !busy) else $error("counter running after expiry"); // R8
  AST_NO_FIRE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_s_q)
    restart |=> !(wd_rst_req || wd_irq)) else $error("fired in restart cycle"); // R10
endmodule

// File: tb/test_wdt_encoded_timer.sv
`timescale 1ns/1ps
module test_wdt_encoded_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wd_wr, wd_rd, tick_16;
  logic [7:0] wd_wdata;
  logic [7:0] wd_rdata;
  logic       wd_timeout, wd_rst_req, wd_irq, wd_cent_clr;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_q [$];   // {rst_req, irq, cent_clr, flag, rdata}
  logic mon_en = 1'b0;

  always #10 clk = ~clk;    // 50 MHz

  wdt_encoded_timer i_wdt_encoded_timer (
    .clk(clk), .rst_n(rst_n), .wd_wr(wd_wr), .wd_rd(wd_rd), .wd_wdata(wd_wdata),
    .tick_16(tick_16), .wd_rdata(wd_rdata), .wd_timeout(wd_timeout),
    .wd_rst_req(wd_rst_req), .wd_irq(wd_irq), .wd_cent_clr(wd_cent_clr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every pulse must match the next expected item
  always @(negedge clk) begin
    if (mon_en && (wd_rst_req || wd_irq || wd_cent_clr)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected pulse actual=%0h expected=none",
                 {wd_rst_req, wd_irq, wd_cent_clr, wd_timeout, wd_rdata});
      end else begin
        automatic logic [11:0] e = exp_q.pop_front();
        if ({wd_rst_req, wd_irq, wd_cent_clr, wd_timeout, wd_rdata} !== e) begin
          errors++;
          $display("FAIL R6/R7 pulse actual=%0h expected=%0h",
                   {wd_rst_req, wd_irq, wd_cent_clr, wd_timeout, wd_rdata}, e);
        end
      end
    end
  end

  task automatic wr_byte(input logic [7:0] b);
    wd_wr = 1'b1; wd_wdata = b;
    @(negedge clk);
    wd_wr = 1'b0;
  endtask

  task automatic rd_byte();
    wd_rd = 1'b1;
    @(negedge clk);
    wd_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_16 = 1'b1;
      @(negedge clk);
    end
    tick_16 = 1'b0;
  endtask

  // N-1 ticks quiet, Nth tick fires with the given expected item
  task automatic run_to_expiry(input string tag, input int n, input logic [11:0] e);
    ticks(n - 1);
    #1 check({tag, " no early flag"}, wd_timeout, 1'b0);
    exp_q.push_back(e);
    ticks(1);
    #1 check({tag, " fired on tick N"}, exp_q.size(), 0);
    check({tag, " flag set"}, wd_timeout, 1'b1);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wd_wr = 1'b0; wd_rd = 1'b0; tick_16 = 1'b0; wd_wdata = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset byte", wd_rdata, 8'h00);
    check("R9 reset outs", {wd_timeout, wd_rst_req, wd_irq, wd_cent_clr}, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    // R1/R7: 0x0D -> mult 3, res 1 -> 12 ticks, interrupt
    wr_byte(8'h0D);
    #1 check("R2 byte stored", wd_rdata, 8'h0D);
    run_to_expiry("R7 mult3 res1", 12, {3'b010, 1'b1, 8'h0D});
    @(negedge clk); #1 check("R7 irq one cycle", wd_irq, 1'b0);
    ticks(30);
    #1 check("R8 flag holds, idle", {wd_timeout, wd_rdata}, {1'b1, 8'h0D});

    // R3: read clears flag, mid-count read restarts
    rd_byte();
    #1 check("R3 read clears flag", wd_timeout, 1'b0);
    check("R3 read keeps byte", wd_rdata, 8'h0D);
    ticks(6);
    rd_byte();
    ticks(11);
    #1 check("R3 mid read postponed expiry", wd_timeout, 1'b0);
    exp_q.push_back({3'b010, 1'b1, 8'h0D});
    ticks(1);
    #1 check("R3 expiry after restart", exp_q.size(), 0);

    // R6: 0x8A -> steer, mult 2, res 2 -> 32 ticks
    wr_byte(8'h8A);
    #1 check("R2 write clears flag", wd_timeout, 1'b0);
    run_to_expiry("R6 steer reset", 32, {3'b101, 1'b1, 8'h00});
    check("R6 byte cleared", wd_rdata, 8'h00);
    @(negedge clk); #1 check("R6 pulses one cycle", {wd_rst_req, wd_cent_clr}, 2'b00);

    // R4: zero byte, and zero multiplier with nonzero resolution
    rd_byte();
    ticks(100);
    #1 check("R4 zero byte silent", wd_timeout, 1'b0);
    wr_byte(8'h03);
    ticks(300);
    #1 check("R4 zero multiplier silent", wd_timeout, 1'b0);

    // R1 boundaries: 1 tick, 4 ticks, 1984 ticks
    wr_byte(8'h04);
    exp_q.push_back({3'b010, 1'b1, 8'h04});
    ticks(1);
    #1 check("R1 one tick interval", exp_q.size(), 0);
    wr_byte(8'h05);
    run_to_expiry("R1 mult1 res1", 4, {3'b010, 1'b1, 8'h05});
    wr_byte(8'h7F);
    run_to_expiry("R1 max interval", 1984, {3'b010, 1'b1, 8'h7F});

    // R10: tick in write cycle not counted (0x08 -> 2 ticks)
    wd_wr = 1'b1; wd_wdata = 8'h08; tick_16 = 1'b1;
    @(negedge clk);
    wd_wr = 1'b0; tick_16 = 1'b0;
    run_to_expiry("R10 tick in write cycle", 2, {3'b010, 1'b1, 8'h08});
    // R10: write beats read (0x0C -> 3 ticks, stored would give 2)
    wd_wr = 1'b1; wd_rd = 1'b1; wd_wdata = 8'h0C;
    @(negedge clk);
    wd_wr = 1'b0; wd_rd = 1'b0;
    #1 check("R10 write wins byte", wd_rdata, 8'h0C);
    run_to_expiry("R10 write wins interval", 3, {3'b010, 1'b1, 8'h0C});

    // R9: reset in mid-count
    wr_byte(8'h8C);
    ticks(2);
    rst_n = 1'b0;
    #1 check("R9 mid reset clears", {wd_timeout, wd_rdata}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ticks(10);
    #1 check("R9 no expiry after reset", {wd_timeout, wd_rst_req}, 2'b00);
    check("R9 queue drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule